// File: doc/BRIEF.md
# Bus Ownership Controller for a DMA Transmit Path

This block decides when a DMA engine asks for a shared system bus and when it gives the bus back. A transmit FIFO reports whether it holds any data and whether it is full. A mode setting chooses which of these two conditions starts a request. Once the arbiter grants the bus, the controller marks the bus busy and strobes transfers while data is present. It leaves the bus after a completed transfer, on a release request, or when an ownership timer runs out.

A hold mode keeps the bus across completed transfers. In that mode the bus stays owned until software clears the mode or a release request arrives. The ownership timer bounds the hold in either mode, which throttles how much of the bus the DMA engine takes. The block also decodes the local burst length for the DMA and FIFO paths separately, and forces that length to four while cache snooping is enabled. A sticky interrupt flag records completion and error events.

Top module: `busown_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `bus_req`, `bus_busy`, `xfer_stb` and `irq` are all 0.
- R2: With `start_on_full` = 0, a non-empty FIFO raises `bus_req` on the next clock edge, provided `rel_req` is low.
- R3: With `start_on_full` = 1, `bus_req` stays low while `fifo_full` is 0, and rises on the edge after `fifo_full` becomes 1.
- R4: `bus_busy` rises only on the edge after a cycle in which both `bus_req` and `bus_grant` were high. While the grant is missing, the request is held and `bus_busy` stays 0.
- R5: With `no_release` = 0, a `dma_done` pulse while busy drops both `bus_req` and `bus_busy` on the next edge.
- R6: With `no_release` = 1, ownership is kept after `dma_done`. Clearing `no_release` after such a completion releases the bus on the next edge.
- R7: `rel_req` high while busy drops `bus_req` and `bus_busy` on the next edge, in every mode. No new request starts while `rel_req` is high.
- R8: With `own_limit` = N (N > 0), `bus_busy` stays high for at most N consecutive cycles, even with `no_release` = 1. N = 0 disables the cap.
- R9: With a path's burst enable at 1, its burst length is 4, 8, 16 or 32 for `blen_code` 00, 01, 10 or 11. With the enable at 0, the length is 1. The DMA path and the FIFO path are decoded independently.
- R10: With `snoop_en` = 1, an enabled path reports a burst length of 4 whatever `blen_code` holds.
- R11: `dma_done` or `dma_err` sets `irq` on the next edge, and `irq` then stays set. `irq_clr` clears it. A set and a clear in the same cycle leave `irq` at 1.
- R12: `xfer_stb` is high exactly when the bus is owned, the FIFO is non-empty, and no release condition is present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_nonempty | input | 1 | Transmit FIFO holds at least one entry |
| fifo_full | input | 1 | Transmit FIFO is full |
| start_on_full | input | 1 | 1: wait for a full FIFO before requesting; 0: request on first data |
| no_release | input | 1 | Hold the bus across completed transfers |
| dma_burst_en | input | 1 | Enable bursts on the DMA path |
| fifo_burst_en | input | 1 | Enable bursts on the FIFO path |
| blen_code | input | 2 | Burst length code (00=4, 01=8, 10=16, 11=32) |
| snoop_en | input | 1 | Snooping active; forces burst length 4 |
| own_limit | input | TMR_W | Maximum cycles of ownership; 0 = no cap |
| bus_grant | input | 1 | Arbiter grant |
| dma_done | input | 1 | DMA transfer completed (one-cycle pulse) |
| dma_err | input | 1 | DMA error (one-cycle pulse) |
| rel_req | input | 1 | Request to give the bus up |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| bus_req | output | 1 | Bus request |
| bus_busy | output | 1 | Bus is owned |
| xfer_stb | output | 1 | Transfer strobe for the current cycle |
| dma_burst_len | output | LEN_W | Local burst length for the DMA path |
| fifo_burst_len | output | LEN_W | Local burst length for the FIFO path |
| irq | output | 1 | Sticky completion/error interrupt |

## Verification
The interrupt flag can receive a new completion or error event in the same cycle as its clear strobe. The bench drives `dma_err` and `irq_clr` together and expects the flag to read 1 afterwards. A timer expiry can also coincide with a hold-mode ownership that would otherwise continue indefinitely. The bench sets `no_release`, programs a limit of five, leaves data in the FIFO, and counts the busy cycles. It expects exactly five.

// File: rtl/busown_pkg.sv
package busown_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_OWN  = 2'd2
    } own_st_e;

    typedef struct packed {
        own_st_e st;
        logic    done_seen;
        logic    irq;
    } ctl_t;

endpackage

// File: rtl/busown_burst_sel.sv
module busown_burst_sel #(
    parameter int CODE_W = 2,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              snoop,
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len
);
    localparam logic [LEN_W-1:0] BASE_LEN = LEN_W'(4);

    always_comb begin
        if (!en)
            len = LEN_W'(1);
        else if (snoop)
            len = BASE_LEN;
        else
            len = BASE_LEN << code;
    end

    // snoop override keeps an enabled path at the minimum burst
    p_snoop_four_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && snoop) |-> (len == BASE_LEN));

    // a disabled path reports single transfers
    p_disabled_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (len == LEN_W'(1)));

endmodule

// File: rtl/busown_hold_timer.sv
module busown_hold_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + TMR_W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (limit != '0) && (cnt_q == limit - TMR_W'(1));

    // once expired, ownership must end on the next edge
    p_cap_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !run);

endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl
    import busown_pkg::*;
#(
    parameter int TMR_W     = 8,
    parameter int MAX_BURST = 32,
    parameter int CODE_W    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_nonempty,
    input  logic                         fifo_full,
    input  logic                         start_on_full,
    input  logic                         no_release,
    input  logic                         dma_burst_en,
    input  logic                         fifo_burst_en,
    input  logic [CODE_W-1:0]            blen_code,
    input  logic                         snoop_en,
    input  logic [TMR_W-1:0]             own_limit,
    input  logic                         bus_grant,
    input  logic                         dma_done,
    input  logic                         dma_err,
    input  logic                         rel_req,
    input  logic                         irq_clr,
    output logic                         bus_req,
    output logic                         bus_busy,
    output logic                         xfer_stb,
    output logic [$clog2(MAX_BURST):0]   dma_burst_len,
    output logic [$clog2(MAX_BURST):0]   fifo_burst_len,
    output logic                         irq
);
    localparam int LEN_W  = $clog2(MAX_BURST) + 1;
    localparam int N_PATH = 2;

    ctl_t ctl_d, ctl_q;
    logic start_now, release_now, tmo;
    logic [N_PATH-1:0]            path_en;
    logic [N_PATH-1:0][LEN_W-1:0] path_len;

    // path 0 = DMA, path 1 = FIFO
    assign path_en = {fifo_burst_en, dma_burst_en};

    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        busown_burst_sel #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (path_en[g]),
            .snoop (snoop_en),
            .code  (blen_code),
            .len   (path_len[g])
        );
    end

    assign dma_burst_len  = path_len[0];
    assign fifo_burst_len = path_len[1];

    busown_hold_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.st == ST_OWN),
        .limit   (own_limit),
        .expired (tmo)
    );

    always_comb begin
        start_now   = (start_on_full ? fifo_full : fifo_nonempty) && !rel_req;
        release_now = (ctl_q.st == ST_OWN) &&
                      (rel_req || tmo ||
                       (!no_release && (dma_done || ctl_q.done_seen)));
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.done_seen = 1'b0;
                if (start_now) ctl_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (bus_grant) ctl_d.st = ST_OWN;
            end
            ST_OWN: begin
                if (dma_done) ctl_d.done_seen = 1'b1;
                if (release_now) begin
                    ctl_d.st        = ST_IDLE;
                    ctl_d.done_seen = 1'b0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (dma_done || dma_err) ctl_d.irq = 1'b1;
        else if (irq_clr)        ctl_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_IDLE;
            ctl_q.done_seen <= 1'b0;
            ctl_q.irq       <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_req  = (ctl_q.st != ST_IDLE);
    assign bus_busy = (ctl_q.st == ST_OWN);
    assign xfer_stb = bus_busy && fifo_nonempty && !release_now;
    assign irq      = ctl_q.irq;

    p_full_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && start_on_full && !fifo_full) |=> !bus_req);

    p_grant_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> $past(bus_req && bus_grant));

    p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && dma_done && !no_release) |=> (!bus_req && !bus_busy));

    p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && no_release && !rel_req && !tmo) |=> bus_busy);

    p_rel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && rel_req) |=> (!bus_req && !bus_busy));

    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done || dma_err) |=> irq);

    p_stb_owned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> (bus_busy && fifo_nonempty));

endmodule

// File: tb/busown_ctrl_tb.sv
module busown_ctrl_tb;
    localparam int TMR_W = 8;
    localparam int LEN_W = 6;
    localparam int NVEC  = 8;
    localparam int VW    = 5 + 2 * LEN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_nonempty = 0, fifo_full = 0, start_on_full = 0, no_release = 0;
    logic dma_burst_en = 0, fifo_burst_en = 0, snoop_en = 0;
    logic [1:0] blen_code = 2'b00;
    logic [TMR_W-1:0] own_limit = '0;
    logic bus_grant = 0, dma_done = 0, dma_err = 0, rel_req = 0, irq_clr = 0;
    logic bus_req, bus_busy, xfer_stb, irq;
    logic [LEN_W-1:0] dma_burst_len, fifo_burst_len;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    busown_ctrl #(.TMR_W(TMR_W), .MAX_BURST(32), .CODE_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_nonempty(fifo_nonempty), .fifo_full(fifo_full),
        .start_on_full(start_on_full), .no_release(no_release),
        .dma_burst_en(dma_burst_en), .fifo_burst_en(fifo_burst_en),
        .blen_code(blen_code), .snoop_en(snoop_en), .own_limit(own_limit),
        .bus_grant(bus_grant), .dma_done(dma_done), .dma_err(dma_err),
        .rel_req(rel_req), .irq_clr(irq_clr), .bus_req(bus_req), .bus_busy(bus_busy),
        .xfer_stb(xfer_stb), .dma_burst_len(dma_burst_len),
        .fifo_burst_len(fifo_burst_len), .irq(irq)
    );

    // {dma_en, fifo_en, snoop, code, expected dma len, expected fifo len}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 1'b0, 2'b00, 6'd4,  6'd4 },
        {1'b1, 1'b1, 1'b0, 2'b01, 6'd8,  6'd8 },
        {1'b1, 1'b0, 1'b0, 2'b10, 6'd16, 6'd1 },
        {1'b0, 1'b1, 1'b0, 2'b11, 6'd1,  6'd32},
        {1'b1, 1'b1, 1'b1, 2'b11, 6'd4,  6'd4 },
        {1'b0, 1'b0, 1'b1, 2'b10, 6'd1,  6'd1 },
        {1'b1, 1'b1, 1'b1, 2'b01, 6'd4,  6'd4 },
        {1'b0, 1'b1, 1'b0, 2'b10, 6'd1,  6'd16}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int busy_cycles;
        // R1: reset state
        step(); step();
        chk("R1 bus_req in reset", bus_req, 0);
        chk("R1 bus_busy in reset", bus_busy, 0);
        rst_n = 1'b1;
        step();
        chk("R1 bus_req after reset", bus_req, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 xfer_stb after reset", xfer_stb, 0);

        // R9/R10: burst length table
        for (int i = 0; i < NVEC; i++) begin
            {dma_burst_en, fifo_burst_en, snoop_en, blen_code} = VEC[i][VW-1 -: 5];
            #1;
            chk("R9/R10 dma_burst_len", dma_burst_len, VEC[i][2*LEN_W-1 -: LEN_W]);
            chk("R9/R10 fifo_burst_len", fifo_burst_len, VEC[i][LEN_W-1:0]);
        end

        // R2: start on first data
        fifo_nonempty = 1;
        step();
        chk("R2 request on first data", bus_req, 1);
        step();
        chk("R4 no busy without grant", bus_busy, 0);
        chk("R4 request held", bus_req, 1);
        bus_grant = 1;
        step();
        chk("R4 busy after grant", bus_busy, 1);
        chk("R12 strobe while owned with data", xfer_stb, 1);
        dma_done = 1;
        #1;
        chk("R12 no strobe on release cycle", xfer_stb, 0);
        fifo_nonempty = 0;
        step();
        dma_done = 0;
        chk("R5 release after done", bus_busy, 0);
        chk("R5 request dropped", bus_req, 0);
        chk("R11 irq set by done", irq, 1);

        // R3: wait for full
        start_on_full = 1; fifo_nonempty = 1; bus_grant = 0;
        step(); step(); step();
        chk("R3 no request before full", bus_req, 0);
        fifo_full = 1;
        step();
        chk("R3 request once full", bus_req, 1);

        // R6: hold mode
        no_release = 1; bus_grant = 1;
        step();
        chk("R6 owned", bus_busy, 1);
        fifo_full = 0; fifo_nonempty = 0;
        dma_done = 1;
        step();
        dma_done = 0;
        chk("R6 kept after done", bus_busy, 1);
        step();
        chk("R6 still kept", bus_busy, 1);
        no_release = 0;
        step();
        chk("R6 released when mode cleared", bus_busy, 0);

        // R7: release request overrides hold
        start_on_full = 0; no_release = 1; fifo_nonempty = 1;
        step(); step();
        chk("R7 owned before release", bus_busy, 1);
        fifo_nonempty = 0; rel_req = 1;
        step();
        chk("R7 busy dropped", bus_busy, 0);
        chk("R7 request dropped", bus_req, 0);
        step();
        chk("R7 no restart under rel_req", bus_req, 0);
        rel_req = 0;

        // R8: ownership cap with hold mode and data pending
        own_limit = 8'd5; fifo_nonempty = 1;
        step(); step();
        busy_cycles = 0;
        for (int k = 0; k < 40; k++) begin
            if (!bus_busy) break;
            busy_cycles++;
            step();
        end
        fifo_nonempty = 0;
        chk("R8 busy cycles capped", busy_cycles, 5);
        step(); step();
        bus_grant = 0; own_limit = '0; no_release = 0;
        step(); step();

        // R11: sticky flag, clear, simultaneous set and clear
        chk("R11 irq still set", irq, 1);
        irq_clr = 1;
        step();
        chk("R11 cleared", irq, 0);
        dma_err = 1;
        step();
        chk("R11 set wins over clear", irq, 1);
        dma_err = 0;
        step();
        irq_clr = 0;
        chk("R11 clear alone", irq, 0);
        dma_err = 1;
        step();
        dma_err = 0;
        step();
        chk("R11 error sets and holds", irq, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule